// File: doc/BRIEF.md
# Shared-Select SPI Register Access Slave

This block is the serial front end of a small register-mapped device. It sits on a four-wire SPI link in mode 0. Up to eight such devices may share one chip select, and each one is told apart by three strap pins. Every transaction opens with a control byte. The control byte carries a fixed four-bit prefix, the three-bit device address and a direction bit. A register-address byte follows, and then any number of data bytes. The block decodes this framing and drives a plain single-cycle register port: a write strobe with address and data, or a read strobe whose returned data is shifted back out on MISO.

The serial inputs are oversampled by the system clock, so all state lives in one clock domain. Two configuration inputs come from the register bank, which is not part of this block. One enables the device-address comparison. The other freezes the register pointer during bursts. When the pointer is allowed to move, it steps once per data byte and wraps from the last register back to zero. Raising chip select abandons whatever transfer is in progress.

Top module: `spi_acc`

## Requirements
- R1: The control byte is accepted only when its bits 7:4 equal 4'b0100; any other prefix leaves the block unaddressed for the rest of the transaction: no register strobe, MISO enable stays low.
- R2: With `cfg_addr_en` high, control-byte bits 3:1 must equal `hw_addr`, otherwise the transaction is ignored exactly as in R1.
- R3: With `cfg_addr_en` low, bits 3:1 are not compared and every device with a valid prefix responds.
- R4: Control bit 0 = 0 selects a write: the byte after the control byte loads the register pointer, and each complete data byte then gives a one-cycle `reg_we` pulse carrying the pointer and the received byte (MSB first, MOSI sampled on SCK rising edges).
- R5: Control bit 0 = 1 selects a read: the register named by the second byte is fetched with a one-cycle `reg_re` pulse and shifted out MSB first. Bit 7 is valid before the first rising SCK edge of the data byte, and later bits change after falling edges.
- R6: With `cfg_seq_dis` low, the pointer advances by one after each data byte, and advances from LAST_REG (default 0x0A) to 0x00.
- R7: With `cfg_seq_dis` high, every data byte of a burst reads or writes the same register.
- R8: Raising chip select at any point aborts the transaction: a partly received byte causes no write, and the next transaction starts from a fresh control byte.
- R9: `spi_miso_oe` is high only while chip select is low, the device is addressed, the operation is a read and the data phase has been reached. `spi_miso` is 0 whenever `spi_miso_oe` is low.
- R10: After synchronous reset (`rst_n` low at a clock edge), `spi_miso_oe`, `reg_we` and `reg_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| hw_addr | input | 3 | Device address straps |
| cfg_addr_en | input | 1 | Compare control-byte address against straps |
| cfg_seq_dis | input | 1 | Hold the register pointer fixed during bursts |
| reg_addr | output | 8 | Register port address |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the same cycle as `reg_re` |

## Verification
On every cycle, the assertions check the following. The bit counter and byte strobe stay clear while chip select is high. The byte strobe is a single-cycle pulse. A sequential write at the last register leaves the pointer at zero. A burst with the pointer frozen leaves the pointer unchanged. MISO is never enabled straight after reset. Other behaviours can only be shown by the bench's scenarios: that a mismatched prefix or address truly suppresses all side effects, that read data appears MSB first with bit 7 ready before the first sampling edge, that a write burst lands at the right registers, and that an aborted byte never reaches the register port.

// File: rtl/spi_acc_pkg.sv
// Package: shared constants and types for the SPI register access slave.
// Assumes 8-bit registers and a 3-bit device address.
package spi_acc_pkg;
    localparam int BYTE_W   = 8;
    localparam int DEVA_W   = 3;
    localparam int BITCNT_W = $clog2(BYTE_W);
    localparam logic [3:0] CTRL_PREFIX = 4'b0100;

    // Position inside a transaction.
    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_REG  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/spi_acc_sync.sv
// Module: multi-bit two-flop synchronizer for independent single-bit lines.
// Assumes each bit is asynchronous and is sampled on its own.
module spi_acc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each line one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= rst_val;
                else        stage[g] <= (g == 0) ? d : stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_acc_shifter.sv
// Module: mode-0 bit engine. Samples MOSI on SCK rising edges, raises a
// one-cycle byte strobe after the eighth bit, and holds a transmit register
// that shifts on falling edges inside a byte. A load overrides shifting.
// Assumes synchronized SCK/MOSI and an SCK half period of several clk cycles.
module spi_acc_shifter
    import spi_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_bit
);
    logic                sck_d;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   rx_sr;
    logic [BYTE_W-1:0]   tx_sr;
    logic                rise, fall;

    assign rise   = sck_s & ~sck_d;
    assign fall   = ~sck_s & sck_d;
    assign tx_bit = tx_sr[BYTE_W-1];

    // Keep the previous SCK sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Receive path: count rising edges, assemble bytes, pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BITCNT_W'(BYTE_W-1)) begin
                    rx_byte   <= {rx_sr[BYTE_W-2:0], mosi_s};
                    byte_done <= 1'b1;
                end
            end
        end
    end

    // Transmit path: load at byte boundaries, shift after falling edges within a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)            tx_sr <= '0;
        else if (load)                    tx_sr <= load_data;
        else if (fall && bit_cnt != '0)   tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end

    // R8: no bit count or byte strobe survives a deasserted chip select.
    p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0) && !byte_done);

    // R4: the byte strobe lasts one cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
endmodule

// File: rtl/spi_acc_ctrl.sv
// Module: transaction sequencer. Decodes the control byte, loads and steps
// the register pointer, and issues single-cycle register strobes.
// Assumes reg_rdata is valid combinationally in the cycle reg_re is high.
module spi_acc_ctrl
    import spi_acc_pkg::*;
#(
    parameter int LAST_REG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [DEVA_W-1:0] hw_addr,
    input  logic              cfg_addr_en,
    input  logic              cfg_seq_dis,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              drive_en
);
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(LAST_REG);

    phase_t            phase;
    logic              sel;
    logic              rd;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] ptr_next;
    logic              hit;

    assign hit = (rx_byte[7:4] == CTRL_PREFIX) &&
                 (!cfg_addr_en || rx_byte[DEVA_W:1] == hw_addr);

    assign ptr_next = cfg_seq_dis ? ptr : ((ptr == LAST) ? '0 : ptr + 1'b1);

    assign reg_addr  = (phase == PH_REG) ? rx_byte : (rd ? ptr_next : ptr);
    assign reg_wdata = rx_byte;
    assign reg_re    = byte_done && sel && rd && (phase != PH_CTRL);
    assign reg_we    = byte_done && sel && !rd && (phase == PH_DATA);
    assign drive_en  = cs_act && sel && rd && (phase == PH_DATA);

    // Advance through the transaction phases and track selection and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            phase <= PH_CTRL;
            sel   <= 1'b0;
            rd    <= 1'b0;
            ptr   <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_CTRL: begin
                    sel   <= hit;
                    rd    <= rx_byte[0];
                    phase <= PH_REG;
                end
                PH_REG: begin
                    ptr   <= rx_byte;
                    phase <= PH_DATA;
                end
                default: ptr <= ptr_next;
            endcase
        end
    end

    // R6: a sequential write at the last register leaves the pointer at zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !cfg_seq_dis && ptr == LAST && cs_act) |=> (ptr == '0));

    // R7: with the pointer frozen, a data byte leaves it unchanged.
    p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && cfg_seq_dis && cs_act) |=> $stable(ptr));

    // R5: read and write strobes never coincide.
    p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
endmodule

// File: rtl/spi_acc.sv
// Module: top of the SPI register access slave. Synchronizes the serial
// lines, then joins the bit engine to the transaction sequencer.
// Assumes SPI mode 0 and a system clock well above the SCK rate.
module spi_acc
    import spi_acc_pkg::*;
#(
    parameter int LAST_REG = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DEVA_W-1:0] hw_addr,
    input  logic              cfg_addr_en,
    input  logic              cfg_seq_dis,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [2:0] line_s;
    logic       cs_act, byte_done, tx_bit, drive_en;
    logic [BYTE_W-1:0] rx_byte;

    spi_acc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b010),
        .d       ({spi_mosi, spi_cs_n, spi_sck}),
        .q       (line_s)
    );

    assign cs_act = ~line_s[1];

    spi_acc_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_s     (line_s[0]),
        .mosi_s    (line_s[2]),
        .load      (reg_re),
        .load_data (reg_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_bit    (tx_bit)
    );

    spi_acc_ctrl #(.LAST_REG(LAST_REG)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .hw_addr     (hw_addr),
        .cfg_addr_en (cfg_addr_en),
        .cfg_seq_dis (cfg_seq_dis),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .drive_en    (drive_en)
    );

    assign spi_miso_oe = drive_en;
    assign spi_miso    = drive_en & tx_bit;

    // R10: MISO is released in the cycle after any reset edge.
    p_oe_reset_r10: assert property (@(posedge clk) !rst_n |=> !spi_miso_oe);

    // R9: a MISO bit is never shown while the driver is disabled.
    p_miso_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);
endmodule

// File: tb/spi_acc_bench.sv
module spi_acc_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic [2:0] hw_addr = 3'b101;
    logic addr_en = 1'b1, seq_dis = 1'b0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_we, reg_re;

    logic [7:0] bank [16];
    int writes = 0;
    int tests = 0, fails = 0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_acc u_spi_acc (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .hw_addr(hw_addr), .cfg_addr_en(addr_en), .cfg_seq_dis(seq_dis),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr[3:0]];

    always @(posedge clk) begin
        if (reg_we) begin
            bank[reg_addr[3:0]] <= reg_wdata;
            writes <= writes + 1;
        end
    end

    always @(negedge clk) if (miso_oe) oe_seen = 1'b1;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); mosi = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0; oe_seen = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk); cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 oe after reset", miso_oe, 0);
        check("R10 no writes after reset", writes, 0);
        check("R10 no read strobe after reset", reg_re, 0);
    endtask

    task automatic t_write_seq();
        logic [7:0] r;
        int w0 = writes;
        cs_low(); xfer(8'h4A, r); xfer(8'h03, r); xfer(8'hA5, r); xfer(8'h5A, r); cs_high();
        check("R4 first write data", bank[3], 8'hA5);
        check("R6 second write at next register", bank[4], 8'h5A);
        check("R4 write count", writes - w0, 2);
    endtask

    task automatic t_read_wrap();
        logic [7:0] r0, r1, r2, r;
        cs_low(); xfer(8'h4B, r); xfer(8'h09, r);
        xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); cs_high();
        check("R5 read first byte", r0, bank[9]);
        check("R6 read second byte", r1, bank[10]);
        check("R6 read wraps to register 0", r2, bank[0]);
        check("R9 oe seen during read", oe_seen, 1);
        check("R9 oe low after cs high", miso_oe, 0);
    endtask

    task automatic t_fixed();
        logic [7:0] r0, r1, r, keep7;
        seq_dis = 1'b1;
        cs_low(); xfer(8'h4B, r); xfer(8'h02, r); xfer(8'h00, r0); xfer(8'h00, r1); cs_high();
        check("R7 fixed read first", r0, bank[2]);
        check("R7 fixed read repeat", r1, bank[2]);
        keep7 = bank[7];
        cs_low(); xfer(8'h4A, r); xfer(8'h06, r); xfer(8'h11, r); xfer(8'h22, r); cs_high();
        check("R7 fixed write last value", bank[6], 8'h22);
        check("R7 next register untouched", bank[7], keep7);
        seq_dis = 1'b0;
    endtask

    task automatic t_wrong_addr();
        logic [7:0] r, keep1;
        int w0 = writes;
        keep1 = bank[1];
        cs_low(); xfer(8'h44, r); xfer(8'h01, r); xfer(8'h77, r); cs_high();
        check("R2 mismatched address no write", writes - w0, 0);
        check("R2 mismatched register unchanged", bank[1], keep1);
        cs_low(); xfer(8'h45, r); xfer(8'h01, r); xfer(8'h00, r); cs_high();
        check("R9 mismatched read never drives", oe_seen, 0);
    endtask

    task automatic t_any_addr();
        logic [7:0] r;
        addr_en = 1'b0;
        cs_low(); xfer(8'h44, r); xfer(8'h01, r); xfer(8'h66, r); cs_high();
        check("R3 address ignored when compare off", bank[1], 8'h66);
        addr_en = 1'b1;
    endtask

    task automatic t_bad_prefix();
        logic [7:0] r;
        int w0 = writes;
        addr_en = 1'b0;
        cs_low(); xfer(8'h8A, r); xfer(8'h05, r); xfer(8'h99, r); cs_high();
        check("R1 bad prefix no write", writes - w0, 0);
        cs_low(); xfer(8'h8B, r); xfer(8'h05, r); xfer(8'h00, r); cs_high();
        check("R1 bad prefix read never drives", oe_seen, 0);
        addr_en = 1'b1;
    endtask

    task automatic t_abort();
        logic [7:0] r;
        int w0 = writes;
        cs_low(); xfer(8'h4A, r); xfer(8'h0C, r); xfer(8'hF0, r, 4); cs_high();
        check("R8 partial byte not written", writes - w0, 0);
        cs_low(); xfer(8'h4A, r); xfer(8'h0D, r); xfer(8'h3C, r); cs_high();
        check("R8 fresh transaction after abort", bank[13], 8'h3C);
        check("R8 single write after abort", writes - w0, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) bank[i] = 8'(i * 17 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_seq();
        t_read_wrap();
        t_fixed();
        t_wrong_addr();
        t_any_addr();
        t_bad_prefix();
        t_abort();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule